// File: doc/BRIEF.md
# Load-Use and Branch Hazard Detector

This block sits in the decode stage of a five-stage in-order pipeline and decides, each cycle, whether the front of the pipeline must hold still. It looks at the two source register indices of the instruction now in decode and at the two older instructions in the execute and memory stages. When an operand cannot yet be supplied by forwarding, the block raises a stall and a bubble. The stall freezes the program counter and the fetch/decode register. The bubble clears the write, read and store controls that would otherwise enter the execute stage.

Two cases cause a stall. The first is a load whose destination is read by the very next instruction. A load result appears only at the end of the memory stage, so that reader waits one cycle. The second is a conditional branch resolved in decode. Its operand must be ready one stage earlier than for an ALU consumer. The branch therefore waits one cycle behind an ALU producer and two cycles behind a load producer. The second of those two cycles is found by matching the load in the memory stage. Register index 31 is the hard zero register and never creates a dependence. Forwarding muxes and branch target arithmetic are outside this block.

Internally, each cycle's situation is reduced to one named cause. `CAUSE_NONE` means no stall. `CAUSE_LOAD_USE` is a load in execute feeding a non-branch. `CAUSE_BR_LOAD_EX` is a load in execute feeding a branch. `CAUSE_BR_ALU` is an ALU result in execute feeding a branch. `CAUSE_BR_LOAD_ME` is a load in memory feeding a branch. The causes are tested in that priority, with the execute-stage matches first, and the outputs are decoded from the cause. The block is purely combinational. It holds no state, so there are no transitions. `clk` and `rst_n` serve only the embedded checks.

Top module: `hz_detect`

## Requirements
- R1: When `ex_is_load` is 1 and `ex_dst` equals `id_src_a` or `id_src_b` (and is not 31), `stall_front` is 1 in the same cycle, whether or not the decode instruction is a branch.
- R2: When `ex_is_load` is 0 and `id_is_cbr` is 0, `stall_front` is 0 for any register indices, including a matching ALU producer in execute or a load in memory.
- R3: A destination index of 31 never causes a stall, in either stage.
- R4: When `id_is_cbr` is 1, `ex_wr` is 1, `ex_is_load` is 0 and `ex_dst` (not 31) equals a decode source, `stall_front` is 1.
- R5: When `id_is_cbr` is 1, `me_is_load` is 1 and `me_dst` (not 31) equals a decode source, `stall_front` is 1.
- R6: `bubble_ex` is 1 exactly in the cycles where `stall_front` is 1 (both active high).
- R7: In a pipeline that inserts the bubble and holds decode while stalled, the stall lasts 1 cycle for a load followed by a dependent non-branch. It lasts 1 cycle for an ALU instruction followed by a dependent branch. It lasts 2 cycles for a load followed by a dependent branch. It lasts 0 cycles for an ALU instruction followed by a dependent non-branch.
- R8: A producer with `ex_wr` = 0 and `ex_is_load` = 0, such as a store, never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded checks only |
| rst_n | input | 1 | Active-low reset, disables the embedded checks |
| ex_is_load | input | 1 | Instruction in execute is a load (memory read) |
| ex_wr | input | 1 | Instruction in execute writes a register |
| ex_dst | input | REG_W | Destination index of the instruction in execute |
| me_is_load | input | 1 | Instruction in memory stage is a load |
| me_dst | input | REG_W | Destination index of the instruction in memory stage |
| id_src_a | input | REG_W | First source index of the decode instruction |
| id_src_b | input | REG_W | Second source index of the decode instruction |
| id_is_cbr | input | 1 | Decode instruction is a conditional branch |
| stall_front | output | 1 | Hold program counter and fetch/decode register |
| bubble_ex | output | 1 | Clear write/read/store controls entering execute |

## Verification
The bench builds the block with its default parameters: 5-bit register indices and 31 as the zero register. This makes register 31 the live corner for R3. Random cycles draw every index from the small pool {0,1,2,3,31}, so matches between the execute, memory and decode fields happen in most cycles. Those cycles are compared against a bench function. A small bench-side pipeline model then feeds producer/consumer pairs and counts stall cycles. This reaches the two-cycle branch-after-load sequence, where the execute-stage match hands over to the memory-stage match.

// File: rtl/hz_pkg.sv
package hz_pkg;
    typedef enum logic [2:0] {
        CAUSE_NONE       = 3'd0,
        CAUSE_LOAD_USE   = 3'd1,
        CAUSE_BR_LOAD_EX = 3'd2,
        CAUSE_BR_ALU     = 3'd3,
        CAUSE_BR_LOAD_ME = 3'd4
    } hz_cause_e;
endpackage

// File: rtl/hz_src_cmp.sv
module hz_src_cmp #(
    parameter int REG_W    = 5,
    parameter int ZERO_REG = 31,
    parameter int N_SRC    = 2
) (
    input  logic                        en,
    input  logic [REG_W-1:0]            dst,
    input  logic [N_SRC-1:0][REG_W-1:0] srcs,
    output logic                        hit
);
    localparam logic [REG_W-1:0] ZERO_IDX = REG_W'(ZERO_REG);

    logic [N_SRC-1:0] eq;
    logic             dst_live;

    assign dst_live = (dst != ZERO_IDX);

    genvar i;
    generate
        for (i = 0; i < N_SRC; i++) begin : g_src
            assign eq[i] = (srcs[i] == dst);
        end
    endgenerate

    assign hit = en && dst_live && (|eq);
endmodule

// File: rtl/hz_cause_sel.sv
module hz_cause_sel
    import hz_pkg::*;
(
    input  logic      ld_ex_hit,
    input  logic      br_alu_hit,
    input  logic      br_ld_me_hit,
    input  logic      is_cbr,
    output hz_cause_e cause
);
    // execute-stage matches take priority over the memory-stage match
    always_comb begin
        cause = CAUSE_NONE;
        if (ld_ex_hit) begin
            cause = is_cbr ? CAUSE_BR_LOAD_EX : CAUSE_LOAD_USE;
        end else if (br_alu_hit) begin
            cause = CAUSE_BR_ALU;
        end else if (br_ld_me_hit) begin
            cause = CAUSE_BR_LOAD_ME;
        end
    end
endmodule

// File: rtl/hz_detect.sv
module hz_detect
    import hz_pkg::*;
#(
    parameter int REG_W    = 5,
    parameter int ZERO_REG = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ex_is_load,
    input  logic             ex_wr,
    input  logic [REG_W-1:0] ex_dst,
    input  logic             me_is_load,
    input  logic [REG_W-1:0] me_dst,
    input  logic [REG_W-1:0] id_src_a,
    input  logic [REG_W-1:0] id_src_b,
    input  logic             id_is_cbr,
    output logic             stall_front,
    output logic             bubble_ex
);
    localparam int N_SRC = 2;
    localparam logic [REG_W-1:0] ZERO_IDX = REG_W'(ZERO_REG);

    logic [N_SRC-1:0][REG_W-1:0] srcs;
    logic      ld_ex_hit, br_alu_hit, br_ld_me_hit;
    logic      en_alu, en_me;
    hz_cause_e cause;

    assign srcs   = {id_src_b, id_src_a};
    assign en_alu = id_is_cbr && ex_wr && !ex_is_load;
    assign en_me  = id_is_cbr && me_is_load;

    hz_src_cmp #(.REG_W(REG_W), .ZERO_REG(ZERO_REG), .N_SRC(N_SRC)) u_cmp_ld_ex (
        .en(ex_is_load), .dst(ex_dst), .srcs(srcs), .hit(ld_ex_hit)
    );

    hz_src_cmp #(.REG_W(REG_W), .ZERO_REG(ZERO_REG), .N_SRC(N_SRC)) u_cmp_alu_ex (
        .en(en_alu), .dst(ex_dst), .srcs(srcs), .hit(br_alu_hit)
    );

    hz_src_cmp #(.REG_W(REG_W), .ZERO_REG(ZERO_REG), .N_SRC(N_SRC)) u_cmp_ld_me (
        .en(en_me), .dst(me_dst), .srcs(srcs), .hit(br_ld_me_hit)
    );

    hz_cause_sel u_sel (
        .ld_ex_hit(ld_ex_hit), .br_alu_hit(br_alu_hit),
        .br_ld_me_hit(br_ld_me_hit), .is_cbr(id_is_cbr), .cause(cause)
    );

    always_comb begin
        unique case (cause)
            CAUSE_LOAD_USE, CAUSE_BR_LOAD_EX,
            CAUSE_BR_ALU, CAUSE_BR_LOAD_ME: begin
                stall_front = 1'b1;
                bubble_ex   = 1'b1;
            end
            default: begin
                stall_front = 1'b0;
                bubble_ex   = 1'b0;
            end
        endcase
    end

    // R1: load in execute feeding a decode source
    a_r1_load_use: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_is_load && ex_dst != ZERO_IDX && (ex_dst == id_src_a || ex_dst == id_src_b))
        |-> stall_front);

    // R2 / R8: without a load in execute and without a branch in decode, never stall
    a_r2_no_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_is_load && !id_is_cbr) |-> !stall_front);

    // R3: zero register in both producer slots never stalls
    a_r3_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_dst == ZERO_IDX && me_dst == ZERO_IDX) |-> !stall_front);

    // R4: branch behind an ALU producer
    a_r4_branch_alu: assert property (@(posedge clk) disable iff (!rst_n)
        (id_is_cbr && ex_wr && ex_dst != ZERO_IDX &&
         (ex_dst == id_src_a || ex_dst == id_src_b)) |-> stall_front);

    // R5: branch behind a load in memory stage
    a_r5_branch_load_me: assert property (@(posedge clk) disable iff (!rst_n)
        (id_is_cbr && me_is_load && me_dst != ZERO_IDX &&
         (me_dst == id_src_a || me_dst == id_src_b)) |-> stall_front);

    // R6: bubble accompanies every stall and nothing else
    a_r6_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_ex == stall_front);
endmodule

// File: tb/sim_hz_detect.sv
module sim_hz_detect;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ex_is_load = 1'b0, ex_wr = 1'b0, me_is_load = 1'b0, id_is_cbr = 1'b0;
    logic [4:0] ex_dst = 5'd31, me_dst = 5'd31, id_src_a = 5'd31, id_src_b = 5'd31;
    logic       stall_front, bubble_ex;
    int         total = 0;
    int         bad = 0;
    bit         ended = 0;

    always #5 clk = ~clk;

    hz_detect #(.REG_W(5), .ZERO_REG(31)) u0 (
        .clk(clk), .rst_n(rst_n),
        .ex_is_load(ex_is_load), .ex_wr(ex_wr), .ex_dst(ex_dst),
        .me_is_load(me_is_load), .me_dst(me_dst),
        .id_src_a(id_src_a), .id_src_b(id_src_b), .id_is_cbr(id_is_cbr),
        .stall_front(stall_front), .bubble_ex(bubble_ex)
    );

    function automatic bit exp_stall(bit ld, bit wr, logic [4:0] d, bit eld,
                                     logic [4:0] ed, logic [4:0] a, logic [4:0] b, bit cbr);
        bit hx, hm;
        hx = (d != 5'd31) && (d == a || d == b);
        hm = (ed != 5'd31) && (ed == a || ed == b);
        return (ld && hx) || (cbr && wr && hx) || (cbr && eld && hm);
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(bit ld, bit wr, logic [4:0] d, bit eld, logic [4:0] ed,
                         logic [4:0] a, logic [4:0] b, bit cbr);
        @(negedge clk);
        ex_is_load = ld; ex_wr = wr; ex_dst = d; me_is_load = eld; me_dst = ed;
        id_src_a = a; id_src_b = b; id_is_cbr = cbr;
        #1;
    endtask

    task automatic dcheck(string tag, bit ld, bit wr, logic [4:0] d, bit eld,
                          logic [4:0] ed, logic [4:0] a, logic [4:0] b, bit cbr, bit exp);
        drive(ld, wr, d, eld, ed, a, b, cbr);
        check(tag, int'(stall_front), int'(exp));
        check("R6 bubble", int'(bubble_ex), int'(exp));
    endtask

    // Bench pipeline model: producer then consumer, then no-ops; counts stall cycles.
    task automatic run_pair(string tag, bit p_ld, bit p_wr, logic [4:0] p_rd,
                            bit c_cbr, logic [4:0] c_a, logic [4:0] c_b, int exp);
        bit         x_ld, x_wr, m_ld, f_ld, f_wr, f_cbr;
        logic [4:0] x_rd, m_rd, f_rd, f_a, f_b;
        int         pc, stalls;
        x_ld = 0; x_wr = 0; x_rd = 5'd31; m_ld = 0; m_rd = 5'd31;
        pc = 0; stalls = 0;
        for (int cyc = 0; cyc < 8; cyc++) begin
            if (pc == 0) begin
                f_ld = p_ld; f_wr = p_wr; f_rd = p_rd; f_cbr = 0; f_a = 5'd31; f_b = 5'd31;
            end else if (pc == 1) begin
                f_ld = 0; f_wr = !c_cbr; f_rd = 5'd31; f_cbr = c_cbr; f_a = c_a; f_b = c_b;
            end else begin
                f_ld = 0; f_wr = 0; f_rd = 5'd31; f_cbr = 0; f_a = 5'd31; f_b = 5'd31;
            end
            drive(x_ld, x_wr, x_rd, m_ld, m_rd, f_a, f_b, f_cbr);
            m_ld = x_ld; m_rd = x_rd;
            if (stall_front) begin
                stalls++;
                x_ld = 0; x_wr = 0; x_rd = 5'd31;
            end else begin
                x_ld = f_ld; x_wr = f_wr; x_rd = f_rd;
                pc++;
            end
        end
        check(tag, stalls, exp);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (2) @(negedge clk);
        #1;
        check("reset stall_front", int'(stall_front), 0);
        check("reset bubble_ex", int'(bubble_ex), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // directed corner cases
        dcheck("R1 load hits src_a", 1, 1, 5'd4, 0, 5'd31, 5'd4, 5'd7, 0, 1);
        dcheck("R1 load hits src_b", 1, 1, 5'd7, 0, 5'd31, 5'd4, 5'd7, 0, 1);
        dcheck("R1 load hits branch src", 1, 1, 5'd7, 0, 5'd31, 5'd7, 5'd1, 1, 1);
        dcheck("R2 alu match non-branch", 0, 1, 5'd4, 0, 5'd31, 5'd4, 5'd4, 0, 0);
        dcheck("R2 me load non-branch", 0, 0, 5'd31, 1, 5'd3, 5'd3, 5'd3, 0, 0);
        dcheck("R3 load dst 31", 1, 1, 5'd31, 0, 5'd31, 5'd31, 5'd31, 0, 0);
        dcheck("R3 me dst 31 branch", 0, 0, 5'd31, 1, 5'd31, 5'd31, 5'd2, 1, 0);
        dcheck("R4 branch behind alu", 0, 1, 5'd9, 0, 5'd31, 5'd1, 5'd9, 1, 1);
        dcheck("R5 branch behind me load", 0, 0, 5'd31, 1, 5'd6, 5'd6, 5'd0, 1, 1);
        dcheck("R8 store producer", 0, 0, 5'd5, 0, 5'd31, 5'd5, 5'd5, 1, 0);
        dcheck("R5 me alu ignored", 0, 0, 5'd31, 0, 5'd6, 5'd6, 5'd6, 1, 0);

        // random sweep over a small index pool
        for (int k = 0; k < 400; k++) begin
            bit         ld, wr, eld, cbr;
            logic [4:0] d, ed, a, b;
            ld = 1'($urandom_range(0, 1)); wr = ld | 1'($urandom_range(0, 1));
            eld = 1'($urandom_range(0, 1)); cbr = 1'($urandom_range(0, 1));
            d  = ($urandom_range(0, 4) == 4) ? 5'd31 : 5'($urandom_range(0, 3));
            ed = ($urandom_range(0, 4) == 4) ? 5'd31 : 5'($urandom_range(0, 3));
            a  = ($urandom_range(0, 4) == 4) ? 5'd31 : 5'($urandom_range(0, 3));
            b  = ($urandom_range(0, 4) == 4) ? 5'd31 : 5'($urandom_range(0, 3));
            dcheck("R1/R2/R3/R4/R5 random", ld, wr, d, eld, ed, a, b, cbr,
                   exp_stall(ld, wr, d, eld, ed, a, b, cbr));
        end

        // pipeline sequences
        run_pair("R7 load then use rn", 1, 1, 5'd2, 0, 5'd2, 5'd31, 1);
        run_pair("R7 load then use rm", 1, 1, 5'd2, 0, 5'd31, 5'd2, 1);
        run_pair("R7 alu then use", 0, 1, 5'd2, 0, 5'd2, 5'd2, 0);
        run_pair("R7 alu then branch", 0, 1, 5'd2, 1, 5'd2, 5'd31, 1);
        run_pair("R7 load then branch", 1, 1, 5'd2, 1, 5'd2, 5'd31, 2);
        run_pair("R3 load x31 then branch", 1, 1, 5'd31, 1, 5'd31, 5'd31, 0);
        run_pair("R7 load unrelated branch", 1, 1, 5'd3, 1, 5'd2, 5'd1, 0);
        run_pair("R8 store then branch", 0, 0, 5'd2, 1, 5'd2, 5'd2, 0);

        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule